// File: doc/BRIEF.md
# Three-wide register renamer with grandparent tags

This block renames a group of three instructions in a single cycle. Each instruction names two architectural sources and one architectural destination. The physical tag for each destination comes from outside the block. For every source, the block returns two things. The first is the physical tag of the producing (parent) instruction. The second is the pair of physical tags that the parent itself consumed (the grandparents), each with a valid bit. A scheduler uses the grandparent tags to wake a consumer speculatively, one cycle before its parent has broadcast.

The mapping table holds one entry per architectural register. An entry contains a physical tag and the two source tags of the instruction that last wrote that register. A source of a later instruction in the group can match the destination of an earlier instruction in the same group. In that case the nearest earlier match takes priority over the table. The grandparent pair is then taken from the resolved source tags of that earlier instruction, under the same select as the parent tag.

The outputs are combinational from the current table and the inputs. When `ren_en` is high, the table is written at the next rising clock edge. Every destination is written, and the youngest writer of a register wins.

Top module: `grp_rename`

## Requirements
- R1: After reset, the entry for architectural register r gives parent tag r, and both grandparent valid bits are 0.
- R2: The first instruction (slot 0) always reads the table, even when one of its sources equals a destination in the same group.
- R3: A slot-1 source equal to the slot-0 destination gives the slot-0 allocated tag as its parent. Its grandparents are the two resolved slot-0 source tags, and both valid bits are 1.
- R4: A slot-2 source that equals both the slot-0 and the slot-1 destinations takes the slot-1 allocated tag and the slot-1 resolved sources.
- R5: A slot-2 source that equals only the slot-0 destination takes the slot-0 allocated tag and the slot-0 resolved sources.
- R6: Grandparent tags taken from a bypass are the producer's resolved parent tags, so a chain inside the group is followed correctly.
- R7: When `ren_en` is high, each destination entry is written with the allocated tag and the writer's two resolved parent tags, both marked valid. Later groups read these values.
- R8: When several slots write the same architectural register, the table keeps the data of the highest-numbered slot.
- R9: When `ren_en` is low, the table is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_en | input | 1 | Commit this group's destinations to the table |
| src_arch | input | 6*AW | Architectural sources; source k = 2*slot+j at bits [k*AW +: AW] |
| dst_arch | input | 3*AW | Architectural destination of slot i at [i*AW +: AW] |
| dst_ptag | input | 3*TW | Allocated physical tag of slot i at [i*TW +: TW] |
| par_ptag | output | 6*TW | Parent tag of source k at [k*TW +: TW] |
| gp_ptag | output | 12*TW | Grandparent j of source k at [(2k+j)*TW +: TW] |
| gp_vld | output | 12 | Valid bit of grandparent j of source k at bit 2k+j |

## Verification
The directed groups each isolate one select path:
- a slot-0 source that collides with its own destination (R2),
- a single earlier match (R3, R5),
- a double match that only the nearest-priority rule resolves (R4),
- a three-deep chain in which the grandparents must come from a bypassed parent (R6).

Groups that read registers after a commit tell table writes apart from bypasses. A same-register triple write shows which writer the table keeps. A disabled group that writes fresh tags, followed by a read-back, shows that the table is held. Random groups over a small register range then mix every match pattern with committed state.

// File: rtl/grp_rename.sv
module grp_rename #(
  parameter int NARCH = 16,
  parameter int NPHYS = 64,
  localparam int AW = $clog2(NARCH),
  localparam int TW = $clog2(NPHYS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ren_en,
  input  logic [6*AW-1:0]  src_arch,
  input  logic [3*AW-1:0]  dst_arch,
  input  logic [3*TW-1:0]  dst_ptag,
  output logic [6*TW-1:0]  par_ptag,
  output logic [12*TW-1:0] gp_ptag,
  output logic [11:0]      gp_vld
);

  logic [TW-1:0] m_tag [NARCH];
  logic [TW-1:0] m_gpa [NARCH];
  logic [TW-1:0] m_gpb [NARCH];
  logic [NARCH-1:0] m_gva, m_gvb;

  logic [AW-1:0] da [3];
  logic [TW-1:0] dt [3];
  logic [AW-1:0] sa [6];
  logic [1:0]    sel [6];
  logic [TW-1:0] rp [6];
  logic [TW-1:0] rga [6];
  logic [TW-1:0] rgb [6];
  logic          rva [6];
  logic          rvb [6];

  for (genvar i = 0; i < 3; i++) begin : g_dst
    assign da[i] = dst_arch[i*AW +: AW];
    assign dt[i] = dst_ptag[i*TW +: TW];
  end

  for (genvar k = 0; k < 6; k++) begin : g_src
    localparam int SLOT = k / 2;
    assign sa[k] = src_arch[k*AW +: AW];
    if (SLOT == 0) begin : g_s0
      assign sel[k] = 2'd0;
      assign rp[k]  = m_tag[sa[k]];
      assign rga[k] = m_gpa[sa[k]];
      assign rgb[k] = m_gpb[sa[k]];
      assign rva[k] = m_gva[sa[k]];
      assign rvb[k] = m_gvb[sa[k]];
    end else if (SLOT == 1) begin : g_s1
      assign sel[k] = (sa[k] == da[0]) ? 2'd1 : 2'd0;
      assign rp[k]  = sel[k][0] ? dt[0] : m_tag[sa[k]];
      assign rga[k] = sel[k][0] ? rp[0] : m_gpa[sa[k]];
      assign rgb[k] = sel[k][0] ? rp[1] : m_gpb[sa[k]];
      assign rva[k] = sel[k][0] | m_gva[sa[k]];
      assign rvb[k] = sel[k][0] | m_gvb[sa[k]];
    end else begin : g_s2
      assign sel[k] = (sa[k] == da[1]) ? 2'd2 :
                      (sa[k] == da[0]) ? 2'd1 : 2'd0;
      always_comb begin
        case (sel[k])
          2'd2: begin
            rp[k] = dt[1]; rga[k] = rp[2]; rgb[k] = rp[3];
            rva[k] = 1'b1; rvb[k] = 1'b1;
          end
          2'd1: begin
            rp[k] = dt[0]; rga[k] = rp[0]; rgb[k] = rp[1];
            rva[k] = 1'b1; rvb[k] = 1'b1;
          end
          default: begin
            rp[k] = m_tag[sa[k]]; rga[k] = m_gpa[sa[k]]; rgb[k] = m_gpb[sa[k]];
            rva[k] = m_gva[sa[k]]; rvb[k] = m_gvb[sa[k]];
          end
        endcase
      end
    end
    assign par_ptag[k*TW +: TW]       = rp[k];
    assign gp_ptag[(2*k)*TW +: TW]    = rga[k];
    assign gp_ptag[(2*k+1)*TW +: TW]  = rgb[k];
    assign gp_vld[2*k]                = rva[k];
    assign gp_vld[2*k+1]              = rvb[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NARCH; r++) begin
        m_tag[r] <= TW'(r);
        m_gpa[r] <= '0;
        m_gpb[r] <= '0;
      end
      m_gva <= '0;
      m_gvb <= '0;
    end else if (ren_en) begin
      for (int i = 0; i < 3; i++) begin
        m_tag[da[i]] <= dt[i];
        m_gpa[da[i]] <= rp[2*i];
        m_gpb[da[i]] <= rp[2*i+1];
        m_gva[da[i]] <= 1'b1;
        m_gvb[da[i]] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/grp_rename_chk.sv
module grp_rename_chk #(
  parameter int AW = 4,
  parameter int TW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ren_en,
  input logic [6*AW-1:0]   src_arch,
  input logic [3*AW-1:0]   dst_arch,
  input logic [3*TW-1:0]   dst_ptag,
  input logic [6*TW-1:0]   par_ptag,
  input logic [12*TW-1:0]  gp_ptag,
  input logic [11:0]       gp_vld
);

  assert_s1_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_arch[2*AW +: AW] == dst_arch[0 +: AW]) |->
      (par_ptag[2*TW +: TW] == dst_ptag[0 +: TW]));

  assert_s2_nearest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_arch[4*AW +: AW] == dst_arch[AW +: AW]) |->
      (par_ptag[4*TW +: TW] == dst_ptag[TW +: TW]));

  assert_gp_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_arch[4*AW +: AW] == dst_arch[AW +: AW]) |->
      (gp_ptag[8*TW +: TW] == par_ptag[2*TW +: TW] &&
       gp_ptag[9*TW +: TW] == par_ptag[3*TW +: TW] && gp_vld[9:8] == 2'b11));

  assert_map_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ren_en |=>
      (src_arch[0 +: AW] != $past(dst_arch[2*AW +: AW]) ||
       (par_ptag[0 +: TW] == $past(dst_ptag[2*TW +: TW]) &&
        gp_ptag[0 +: TW] == $past(par_ptag[4*TW +: TW]) &&
        gp_vld[1:0] == 2'b11)));

endmodule

bind grp_rename grp_rename_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_en(ren_en), .src_arch(src_arch),
  .dst_arch(dst_arch), .dst_ptag(dst_ptag), .par_ptag(par_ptag),
  .gp_ptag(gp_ptag), .gp_vld(gp_vld));

// File: tb/grp_rename_bench.sv
`timescale 1ns/1ps
module grp_rename_bench;
  localparam int AW = 4;
  localparam int TW = 6;
  localparam int NA = 16;

  logic clk = 0, rst_n = 0, ren_en = 0;
  logic [6*AW-1:0]  src_arch = '0;
  logic [3*AW-1:0]  dst_arch = '0;
  logic [3*TW-1:0]  dst_ptag = '0;
  logic [6*TW-1:0]  par_ptag;
  logic [12*TW-1:0] gp_ptag;
  logic [11:0]      gp_vld;

  always #10 clk = ~clk;

  grp_rename #(.NARCH(16), .NPHYS(64)) u_grp_rename (
    .clk(clk), .rst_n(rst_n), .ren_en(ren_en), .src_arch(src_arch),
    .dst_arch(dst_arch), .dst_ptag(dst_ptag), .par_ptag(par_ptag),
    .gp_ptag(gp_ptag), .gp_vld(gp_vld));

  typedef struct packed {
    logic [6*TW-1:0]  par;
    logic [12*TW-1:0] gp;
    logic [11:0]      gv;
  } exp_t;

  exp_t  q[$];
  string rq[$];
  int tests = 0, fails = 0;
  bit done = 0;

  logic [TW-1:0] mt [NA];
  logic [TW-1:0] ma [NA];
  logic [TW-1:0] mb [NA];
  logic          mva [NA];
  logic          mvb [NA];

  task automatic model_reset();
    for (int r = 0; r < NA; r++) begin
      mt[r] = TW'(r); ma[r] = '0; mb[r] = '0; mva[r] = 0; mvb[r] = 0;
    end
  endtask

  task automatic grp(input string req, input bit en, input logic [6*AW-1:0] s,
                     input logic [3*AW-1:0] d, input logic [3*TW-1:0] t);
    exp_t e;
    logic [TW-1:0] ep [6];
    @(posedge clk); #2;
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] a;
      logic [TW-1:0] p, ga, gb;
      logic va, vb;
      a = s[k*AW +: AW];
      p = mt[a]; ga = ma[a]; gb = mb[a]; va = mva[a]; vb = mvb[a];
      if (k >= 2 && a == d[0 +: AW]) begin
        p = t[0 +: TW]; ga = ep[0]; gb = ep[1]; va = 1; vb = 1;
      end
      if (k >= 4 && a == d[AW +: AW]) begin
        p = t[TW +: TW]; ga = ep[2]; gb = ep[3]; va = 1; vb = 1;
      end
      ep[k] = p;
      e.par[k*TW +: TW] = p;
      e.gp[(2*k)*TW +: TW] = ga;
      e.gp[(2*k+1)*TW +: TW] = gb;
      e.gv[2*k] = va;
      e.gv[2*k+1] = vb;
    end
    src_arch = s; dst_arch = d; dst_ptag = t; ren_en = en;
    q.push_back(e); rq.push_back(req);
    if (en) begin
      for (int i = 0; i < 3; i++) begin
        logic [AW-1:0] w;
        w = d[i*AW +: AW];
        mt[w] = t[i*TW +: TW]; ma[w] = ep[2*i]; mb[w] = ep[2*i+1];
        mva[w] = 1; mvb[w] = 1;
      end
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string r;
      e = q.pop_front(); r = rq.pop_front();
      tests++;
      if (par_ptag !== e.par) begin
        fails++;
        $display("FAIL %s parent tags: got %h expected %h", r, par_ptag, e.par);
      end
      tests++;
      if (gp_ptag !== e.gp || gp_vld !== e.gv) begin
        fails++;
        $display("FAIL %s grandparents: got %h/%b expected %h/%b",
                 r, gp_ptag, gp_vld, e.gp, e.gv);
      end
    end
  end

  function automatic logic [6*AW-1:0] S(input int a0, a1, b0, b1, c0, c1);
    return {AW'(c1), AW'(c0), AW'(b1), AW'(b0), AW'(a1), AW'(a0)};
  endfunction
  function automatic logic [3*AW-1:0] D(input int a, b, c);
    return {AW'(c), AW'(b), AW'(a)};
  endfunction
  function automatic logic [3*TW-1:0] T(input int a, b, c);
    return {TW'(c), TW'(b), TW'(a)};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: identity after reset, grandparents invalid
    grp("R1", 0, S(0,1,2,3,4,5), D(6,7,8), T(40,41,42));
    grp("R1", 0, S(15,14,13,12,11,10), D(0,0,0), T(1,2,3));
    // R2 slot 0 reads table despite own dst; R3 slot 1 bypass from slot 0
    grp("R2", 1, S(3,4,3,9,9,9), D(3,10,11), T(40,41,42));
    // R4: slot 2 matches both slot 0 and slot 1 dst
    grp("R4", 1, S(1,2,0,5,5,0), D(5,5,12), T(43,44,45));
    // R5: slot 2 matches only slot 0
    grp("R5", 1, S(6,7,1,2,6,13), D(13,14,15), T(46,47,48));
    // R6: chain 0 -> 1 -> 2 inside group
    grp("R6", 1, S(2,3,1,8,4,9), D(1,4,9), T(50,51,52));
    // R7: read committed entries
    grp("R7", 0, S(1,4,9,5,13,3), D(0,0,0), T(0,0,0));
    // R8: three writers of one register
    grp("R8", 1, S(0,2,3,4,6,8), D(7,7,7), T(53,54,55));
    grp("R8", 0, S(7,7,7,0,0,7), D(1,2,3), T(0,0,0));
    // R9: disabled group with fresh dsts leaves table intact
    grp("R9", 0, S(11,12,11,12,11,12), D(11,12,0), T(60,61,62));
    grp("R9", 0, S(11,12,0,0,11,12), D(1,2,3), T(0,0,0));
    // mixed random groups over a small register range
    for (int n = 0; n < 300; n++) begin
      logic [6*AW-1:0] s;
      logic [3*AW-1:0] d;
      logic [3*TW-1:0] t;
      for (int k = 0; k < 6; k++) s[k*AW +: AW] = AW'($urandom_range(0, 5));
      for (int i = 0; i < 3; i++) begin
        d[i*AW +: AW] = AW'($urandom_range(0, 5));
        t[i*TW +: TW] = TW'($urandom_range(16, 63));
      end
      grp("R7", ($urandom_range(0, 3) != 0), s, d, t);
    end
    @(posedge clk); #2 ren_en = 0;
    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule